// File: doc/BRIEF.md
# Clamped Three-Channel Fan PWM Driver

This block drives three fan outputs with 8-bit pulse-width modulation. Each channel holds a duty request and a ceiling. The output duty is the smaller of the two. A shared free-running 8-bit counter sets a 256-cycle period. A channel picks up a new applied duty only when a period wraps, so a change never cuts a pulse short.

Each channel is in one of two modes. In automatic mode the duty request copies an external control value every cycle, and host writes to it are dropped. In manual mode the host writes the request directly. When a channel is enabled it first runs a spin-up phase of a configurable number of periods. During spin-up the output is held high and the request reads back as zero. A one-way lock bit freezes the ceiling registers until the next reset.

A simple write port and a combinational read port give access to the registers. The host bus protocol and the thermal control loop sit outside the block.

Top module: `fan_pwm_clamp`

## Requirements
- R1: After reset, every duty request reads 0xFF, every ceiling reads 0xFF, the lock bit reads 0, and every output is low while its channel is disabled.
- R2: Address map (3-bit address):
  - 0, 1, 2: duty request of channels 0 to 2.
  - 4, 5, 6: ceiling of channels 0 to 2.
  - 7: lock bit, in data bit 0.
  - Any other address reads 0. Reads are combinational from `rd_addr`.
- R3: With a steady applied duty d, an enabled channel that is past spin-up is high for exactly d cycles of every 256-cycle period when d is 0x00 to 0xFE. When d is 0xFF the output is high continuously.
- R4: The applied duty is min(duty request, ceiling). The duty request still reads back the unclamped value.
- R5: A change to the applied duty takes effect only from the first cycle of the next counter period. The current period completes with the old duty.
- R6: In manual mode, a host write to a duty-request address updates that register, and a read returns the new value on the following cycle.
- R7: In automatic mode, the duty request takes the channel's `auto_duty` value one cycle later, and host writes to it are ignored. When the channel leaves automatic mode, the request keeps its last value.
- R8: Writing 1 to bit 0 at address 7 sets the lock bit. While the lock bit is set, writes to the ceiling addresses are ignored. Writing 0 does not clear the lock bit; only reset does.
- R9: A rising `chan_en` starts spin-up. Spin-up lasts until the STARTUP_PERIODS-th counter wrap after that rise. During spin-up the output is continuously high and the channel's duty request reads 0x00.
- R10: One cycle after `chan_en` is low, the output is low and any spin-up in progress is cancelled. A later rise of `chan_en` starts spin-up again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| chan_en | input | 3 | Per-channel enable |
| auto_mode | input | 3 | Per-channel automatic-mode select |
| auto_duty | input | 24 | Duty value from the external controller, 8 bits per channel, channel 0 in the low byte |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data |
| pwm_out | output | 3 | Fan PWM outputs |

## Verification
Each result is due after a different number of cycles, and each check waits exactly that long:

- **Register writes** become visible to the combinational read one clock after the write strobe is sampled, so the bench reads at the next falling edge.
- **Automatic-mode requests** follow `auto_duty` with a one-cycle delay, and are read the same way.
- **Output duty** changes only at a counter wrap. The bench therefore waits at least two full periods before counting high cycles over a 256-cycle window.
- **Period boundary (R5):** the bench aligns to the output's rising edge, which marks counter zero. It checks that the rest of that period still carries the old duty and that the next full period carries the new one.
- **Spin-up (R9):** spin-up ends between 257 and 512 cycles after enable, depending on the counter phase. Its window checks therefore fit inside the shortest case, and its end check starts after the longest.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  parameter int DUTY_W = 8;
  typedef logic [DUTY_W-1:0] duty_t;
  localparam duty_t DUTY_FULL = '1;

  function automatic duty_t clamp_duty(input duty_t req, input duty_t lim);
    return (req > lim) ? lim : req;
  endfunction
endpackage

// File: rtl/fpc_rst_sync.sv
module fpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/fpc_regs.sv
module fpc_regs
  import fpc_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  duty_t                        wr_data,
  input  logic [AW-1:0]                rd_addr,
  input  logic [NCH-1:0]               auto_mode,
  input  logic [NCH-1:0][DUTY_W-1:0]   auto_duty,
  input  logic [NCH-1:0]               startup,
  output duty_t                        rd_data,
  output logic [NCH-1:0][DUTY_W-1:0]   duty_q,
  output logic [NCH-1:0][DUTY_W-1:0]   max_q,
  output logic                         lock_q
);
  localparam int CW = AW - 1;
  localparam logic [AW-1:0] LOCK_ADDR = {1'b1, CW'(NCH)};

  logic [NCH-1:0]             duty_we, max_we;
  logic [NCH-1:0][DUTY_W-1:0] duty_nx;
  logic                       lock_set;

  // next-state / enables
  always_comb begin
    lock_set = wr_en && (wr_addr == LOCK_ADDR) && wr_data[0];
    for (int i = 0; i < NCH; i++) begin
      duty_we[i] = auto_mode[i] || (wr_en && (wr_addr == {1'b0, CW'(i)}));
      duty_nx[i] = auto_mode[i] ? auto_duty[i] : wr_data;
      max_we[i]  = wr_en && !lock_q && (wr_addr == {1'b1, CW'(i)});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= {NCH{DUTY_FULL}};
      max_q  <= {NCH{DUTY_FULL}};
      lock_q <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (duty_we[i]) duty_q[i] <= duty_nx[i];
        if (max_we[i])  max_q[i]  <= wr_data;
      end
      if (lock_set) lock_q <= 1'b1;
    end
  end

  // readback
  always_comb begin
    rd_data = '0;
    if (rd_addr == LOCK_ADDR) rd_data = duty_t'(lock_q);
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == {1'b0, CW'(i)}) rd_data = startup[i] ? '0 : duty_q[i];
      if (rd_addr == {1'b1, CW'(i)}) rd_data = max_q[i];
    end
  end
endmodule

// File: rtl/fpc_channel.sv
module fpc_channel
  import fpc_pkg::*;
#(
  parameter int STARTUP_PERIODS = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  duty_t cnt,
  input  logic  wrap,
  input  duty_t req_duty,
  input  duty_t max_duty,
  output logic  pwm,
  output logic  startup,
  output duty_t act_duty
);
  localparam int SW = (STARTUP_PERIODS > 0) ? $clog2(STARTUP_PERIODS + 1) : 1;
  localparam logic [SW-1:0] SU_LOAD = SW'(STARTUP_PERIODS);

  logic          en_q;
  logic [SW-1:0] su_q, su_d;
  duty_t         act_q;

  always_comb begin
    su_d = su_q;
    if (!en)                     su_d = '0;
    else if (!en_q)              su_d = SU_LOAD;
    else if (wrap && su_q != '0) su_d = su_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      su_q  <= '0;
      act_q <= DUTY_FULL;
    end else begin
      en_q <= en;
      su_q <= su_d;
      if (wrap) act_q <= clamp_duty(req_duty, max_duty);
    end
  end

  assign startup  = (su_q != '0);
  assign act_duty = act_q;
  assign pwm      = en_q && (startup || (act_q == DUTY_FULL) || (cnt < act_q));
endmodule

// File: rtl/fan_pwm_clamp.sv
module fan_pwm_clamp
  import fpc_pkg::*;
#(
  parameter int NCH             = 3,
  parameter int STARTUP_PERIODS = 4,
  localparam int AW             = $clog2(NCH + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          chan_en,
  input  logic [NCH-1:0]          auto_mode,
  input  logic [NCH*DUTY_W-1:0]   auto_duty,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DUTY_W-1:0]       wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [DUTY_W-1:0]       rd_data,
  output logic [NCH-1:0]          pwm_out
);
  logic                       rst_sync_n;
  duty_t                      cnt_q;
  logic                       wrap;
  logic [NCH-1:0][DUTY_W-1:0] auto_duty_v, duty_q, max_q, act_q;
  logic [NCH-1:0]             su_act;
  logic                       lock_q;

  assign auto_duty_v = auto_duty;

  fpc_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
  assign wrap = (cnt_q == DUTY_FULL);

  fpc_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .auto_mode(auto_mode),
    .auto_duty(auto_duty_v), .startup(su_act), .rd_data(rd_data),
    .duty_q(duty_q), .max_q(max_q), .lock_q(lock_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    fpc_channel #(.STARTUP_PERIODS(STARTUP_PERIODS)) u_ch (
      .clk(clk), .rst_n(rst_sync_n), .en(chan_en[i]), .cnt(cnt_q), .wrap(wrap),
      .req_duty(duty_q[i]), .max_duty(max_q[i]), .pwm(pwm_out[i]),
      .startup(su_act[i]), .act_duty(act_q[i])
    );
  end
endmodule

// File: rtl/fpc_chk.sv
module fpc_chk
  import fpc_pkg::*;
#(
  parameter int NCH = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NCH-1:0]             chan_en,
  input logic [NCH-1:0]             auto_mode,
  input logic [NCH-1:0][DUTY_W-1:0] auto_duty_v,
  input logic [NCH-1:0]             pwm_out,
  input logic [NCH-1:0]             su_act,
  input logic [NCH-1:0][DUTY_W-1:0] duty_q,
  input logic [NCH-1:0][DUTY_W-1:0] max_q,
  input logic [NCH-1:0][DUTY_W-1:0] act_q,
  input duty_t                      cnt_q,
  input logic                       lock_q
);
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> lock_q);
  a_r8_max_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> $stable(max_q));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r5_hold_in_period: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> $stable(act_q[i]));
    a_r4_under_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |-> (act_q[i] <= $past(max_q[i])));
    a_r9_spinup_high: assert property (@(posedge clk) disable iff (!rst_n)
      su_act[i] |-> pwm_out[i]);
    a_r10_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!chan_en[i]) |-> !pwm_out[i]);
    a_r7_auto_follow: assert property (@(posedge clk) disable iff (!rst_n)
      $past(auto_mode[i]) |-> (duty_q[i] == $past(auto_duty_v[i])));
    a_r3_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((act_q[i] == '0) && !su_act[i]) |-> !pwm_out[i]);
  end
endmodule

bind fan_pwm_clamp fpc_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .chan_en(chan_en), .auto_mode(auto_mode),
  .auto_duty_v(auto_duty_v), .pwm_out(pwm_out), .su_act(su_act),
  .duty_q(duty_q), .max_q(max_q), .act_q(act_q), .cnt_q(cnt_q), .lock_q(lock_q)
);

// File: tb/fan_pwm_clamp_tb_top.sv
module fan_pwm_clamp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  chan_en, auto_mode;
  logic [23:0] auto_duty;
  logic        wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [7:0]  wr_data, rd_data;
  logic [2:0]  pwm_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fan_pwm_clamp #(.NCH(3), .STARTUP_PERIODS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .auto_mode(auto_mode),
    .auto_duty(auto_duty), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; chan_en = '0; auto_mode = '0; auto_duty = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
  endtask

  task automatic enable_and_settle(input int ch);
    chan_en[ch] = 1'b1;
    repeat (3 * 256 + 8) @(negedge clk);
  endtask

  task automatic t_reset();
    int v, hi;
    do_reset();
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      if (a == 7)      chk("R1 lock reset", v, 0);
      else if (a == 3) chk("R2 unmapped addr reads 0", v, 0);
      else             chk("R1 register reset", v, 255);
    end
    count_high(0, 300, hi);
    chk("R1 output low while disabled", hi, 0);
  endtask

  task automatic t_levels();
    int v, hi;
    int lv[5] = '{0, 1, 128, 254, 255};
    do_reset();
    enable_and_settle(0);
    foreach (lv[j]) begin
      wr(3'd0, 8'(lv[j]));
      rd(3'd0, v);
      chk("R6 manual write readback", v, lv[j]);
      repeat (520) @(negedge clk);
      count_high(0, 256, hi);
      chk("R3 high cycles per period", hi, (lv[j] == 255) ? 256 : lv[j]);
    end
  endtask

  task automatic t_clamp();
    int v, hi;
    do_reset();
    enable_and_settle(1);
    wr(3'd5, 8'd100);
    wr(3'd1, 8'd200);
    rd(3'd1, v); chk("R4 request reads unclamped", v, 200);
    rd(3'd5, v); chk("R4 ceiling readback", v, 100);
    repeat (520) @(negedge clk);
    count_high(1, 256, hi); chk("R4 output clamped to ceiling", hi, 100);
    wr(3'd1, 8'd50);
    repeat (520) @(negedge clk);
    count_high(1, 256, hi); chk("R4 request below ceiling", hi, 50);
  endtask

  task automatic t_boundary();
    int hi;
    do_reset();
    enable_and_settle(0);
    wr(3'd0, 8'd64);
    repeat (520) @(negedge clk);
    do @(negedge clk); while (pwm_out[0]);
    do @(negedge clk); while (!pwm_out[0]);
    // now in the counter-zero cycle
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'd192;
    hi = 0;
    for (int k = 0; k < 255; k++) begin
      @(negedge clk);
      if (k == 0) wr_en = 1'b0;
      if (pwm_out[0]) hi++;
    end
    chk("R5 rest of period keeps old duty", hi, 63);
    count_high(0, 256, hi);
    chk("R5 next period uses new duty", hi, 192);
  endtask

  task automatic t_auto();
    int v, hi;
    do_reset();
    enable_and_settle(2);
    auto_mode[2] = 1'b1; auto_duty[23:16] = 8'd90;
    @(negedge clk);
    rd(3'd2, v); chk("R7 request follows auto input", v, 90);
    wr(3'd2, 8'd30);
    rd(3'd2, v); chk("R7 host write ignored in auto", v, 90);
    repeat (520) @(negedge clk);
    count_high(2, 256, hi); chk("R7 output from auto duty", hi, 90);
    auto_duty[23:16] = 8'd40;
    @(negedge clk);
    rd(3'd2, v); chk("R7 one-cycle follow", v, 40);
    auto_mode[2] = 1'b0; auto_duty[23:16] = 8'd7;
    @(negedge clk);
    rd(3'd2, v); chk("R7 holds after leaving auto", v, 40);
    wr(3'd2, 8'd33);
    rd(3'd2, v); chk("R6 manual write after auto", v, 33);
  endtask

  task automatic t_startup();
    int v, hi;
    do_reset();
    wr(3'd0, 8'd100);
    chan_en[0] = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R9 readback zero in spin-up", v, 0);
    count_high(0, 200, hi); chk("R9 output high in spin-up", hi, 200);
    repeat (600) @(negedge clk);
    rd(3'd0, v); chk("R9 readback after spin-up", v, 100);
    count_high(0, 256, hi); chk("R9 normal duty after spin-up", hi, 100);
  endtask

  task automatic t_lock();
    int v, hi;
    do_reset();
    wr(3'd4, 8'd80);
    wr(3'd7, 8'd1);
    rd(3'd7, v); chk("R8 lock set", v, 1);
    wr(3'd4, 8'd150);
    rd(3'd4, v); chk("R8 ceiling write ignored when locked", v, 80);
    wr(3'd7, 8'd0);
    rd(3'd7, v); chk("R8 lock not cleared by write", v, 1);
    enable_and_settle(0);
    count_high(0, 256, hi); chk("R8 locked ceiling still clamps", hi, 80);
    do_reset();
    rd(3'd7, v); chk("R8 reset clears lock", v, 0);
    rd(3'd4, v); chk("R1 ceiling back to full", v, 255);
  endtask

  task automatic t_disable();
    int v, hi;
    do_reset();
    enable_and_settle(0);
    wr(3'd0, 8'd255);
    repeat (520) @(negedge clk);
    chan_en[0] = 1'b0;
    @(negedge clk);
    count_high(0, 300, hi); chk("R10 output low when disabled", hi, 0);
    chan_en[0] = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R10 re-enable restarts spin-up", v, 0);
    chan_en[0] = 1'b0;
    @(negedge clk);
    rd(3'd0, v); chk("R10 spin-up cancelled", v, 255);
  endtask

  initial begin
    bit timed_out = 1'b0;
    fork
      begin
        t_reset(); t_levels(); t_clamp(); t_boundary();
        t_auto(); t_startup(); t_lock(); t_disable();
      end
      begin
        repeat (190000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule